// File: doc/BRIEF.md
# Deferred condition-flag evaluator

This block reconstructs the four condition flags (negative, zero, carry, overflow) of a processor model from a compact record of the last flag-setting operation. Instead of an ALU updating the flags at the moment it computes, the model stores a small descriptor: a 4-bit operation code and three operand words. The flags are only worked out when something asks for them. The descriptor packs auxiliary bits per operation: the old carry, the shifter carry-out and the old overflow.

Each clock edge samples the descriptor and registers a status word. The flags occupy the four most significant bits, and every lower bit is zero. The datapath width is a parameter (default 32). The add and subtract families share one adder. The logical, multiply and copy modes are plain field selects.

Top module: `nzcv_thunk_eval`

## Requirements
- R1: While `rst_n` is low the output is all zero; otherwise `flags_out` shows the result for the inputs sampled at the previous rising edge.
- R2: In the output, N is bit W-1, Z is bit W-2, C is bit W-3 and V is bit W-4; bits W-5..0 are always zero.
- R3: Op code 0 (copy) puts `dep_a` bits W-1..W-4 into the four flag positions unchanged.
- R4: Op code 1 (add) computes `dep_a + dep_b`. N is the sum's MSB and Z is set when the sum is zero. C is the unsigned carry out. V is set when both operands share a sign that differs from the sum's sign.
- R5: Op code 2 (subtract) computes `dep_a - dep_b`. C is set when no borrow occurs (`dep_a >= dep_b` unsigned). V is set when the operands differ in sign and the result's sign differs from `dep_a`'s. N and Z follow the difference.
- R6: Op code 3 (add with carry) adds `dep_c` bit 0 to the sum. Op code 4 (subtract with carry) computes `dep_a - dep_b - (1 - dep_c[0])`. Both use the carry and overflow meanings of R4 and R5 respectively.
- R7: Op code 5 (logical) takes N and Z from `dep_a`, C from `dep_b` bit 0, and V from `dep_c` bit 0.
- R8: Op code 6 (single multiply) takes N and Z from `dep_a`, C from `dep_c` bit 1, and V from `dep_c` bit 0.
- R9: Op code 7 (double multiply) treats `dep_b:dep_a` as one product. N is the MSB of `dep_b`, and Z is set only when both words are zero. C and V come from `dep_c` bits 1 and 0.
- R10: Op codes 8 to 15 give an all-zero output word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_code | input | 4 | Recorded operation kind |
| dep_a | input | W | First operand word (left operand, result, or low product) |
| dep_b | input | W | Second operand word (right operand, shifter carry, or high product) |
| dep_c | input | W | Third word holding old carry/overflow in its low bits |
| flags_out | output | W | Registered status word with the flags in the top four bits |

## Verification
The assertions assume that the inputs are known and stable across each rising edge. They also assume that the bits of `dep_c` above bit 1 are zero, as the descriptor format promises, although the logic ignores those bits. The bench drives every descriptor on the falling edge and fills only the bit fields that each operation defines. It sweeps all operand pairs and auxiliary bits on a 6-bit instance, so every carry and sign boundary is reached.

// File: rtl/flag_thunk_pkg.sv
package flag_thunk_pkg;
  localparam int OP_W = 4;
  localparam int FLAG_N = 4;

  typedef enum logic [OP_W-1:0] {
    TH_COPY  = 4'd0,
    TH_ADD   = 4'd1,
    TH_SUB   = 4'd2,
    TH_ADC   = 4'd3,
    TH_SBB   = 4'd4,
    TH_LOGIC = 4'd5,
    TH_MUL   = 4'd6,
    TH_MULL  = 4'd7
  } thunk_op_e;

  function automatic logic op_is_arith(input logic [OP_W-1:0] op);
    return (op == TH_ADD) || (op == TH_SUB) || (op == TH_ADC) || (op == TH_SBB);
  endfunction

  function automatic logic op_is_sub(input logic [OP_W-1:0] op);
    return (op == TH_SUB) || (op == TH_SBB);
  endfunction
endpackage

// File: rtl/thunk_addsub.sv
module thunk_addsub
  import flag_thunk_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [OP_W-1:0] op,
  input  logic [W-1:0]    lhs,
  input  logic [W-1:0]    rhs,
  input  logic            old_c,
  output logic [W-1:0]    sum,
  output logic            carry,
  output logic            ovf
);
  localparam int MSB = W - 1;

  function automatic logic carry_in(input logic [OP_W-1:0] o, input logic c);
    case (o)
      TH_ADD:         return 1'b0;
      TH_SUB:         return 1'b1;
      TH_ADC, TH_SBB: return c;
      default:        return 1'b0;
    endcase
  endfunction

  logic [W-1:0] rhs_eff;
  logic [W:0]   wide;

  always_comb begin
    rhs_eff = op_is_sub(op) ? ~rhs : rhs;
    wide    = {1'b0, lhs} + {1'b0, rhs_eff} + {{W{1'b0}}, carry_in(op, old_c)};
    sum     = wide[W-1:0];
    carry   = wide[W];
    ovf     = (lhs[MSB] == rhs_eff[MSB]) && (sum[MSB] != lhs[MSB]);
  end
endmodule

// File: rtl/thunk_select.sv
module thunk_select
  import flag_thunk_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [OP_W-1:0]   op,
  input  logic [W-1:0]      dep_a,
  input  logic [W-1:0]      dep_b,
  input  logic [1:0]        aux,
  input  logic [W-1:0]      as_sum,
  input  logic              as_carry,
  input  logic              as_ovf,
  output logic [FLAG_N-1:0] nzcv
);
  localparam int MSB = W - 1;

  always_comb begin
    case (op)
      TH_COPY:                        nzcv = dep_a[MSB -: FLAG_N];
      TH_ADD, TH_SUB, TH_ADC, TH_SBB: nzcv = {as_sum[MSB], as_sum == '0, as_carry, as_ovf};
      TH_LOGIC:                       nzcv = {dep_a[MSB], dep_a == '0, dep_b[0], aux[0]};
      TH_MUL:                         nzcv = {dep_a[MSB], dep_a == '0, aux[1], aux[0]};
      TH_MULL:                        nzcv = {dep_b[MSB], (dep_a | dep_b) == '0, aux[1], aux[0]};
      default:                        nzcv = '0;
    endcase
  end
endmodule

// File: rtl/nzcv_thunk_eval.sv
module nzcv_thunk_eval
  import flag_thunk_pkg::*;
#(
  parameter int W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [3:0]      op_code,
  input  logic [W-1:0]    dep_a,
  input  logic [W-1:0]    dep_b,
  input  logic [W-1:0]    dep_c,
  output logic [W-1:0]    flags_out
);
  localparam int LOW_W = W - FLAG_N;
  localparam int BIT_N = W - 1;
  localparam int BIT_Z = W - 2;
  localparam int BIT_C = W - 3;
  localparam int BIT_V = W - 4;

  logic [W-1:0]      as_sum;
  logic              as_carry;
  logic              as_ovf;
  logic [FLAG_N-1:0] nzcv;
  logic              op_legal;
  logic              unused_dep_c_hi;

  assign op_legal        = (op_code < 4'd8);
  assign unused_dep_c_hi = ^dep_c[W-1:2];

  thunk_addsub #(.W(W)) u_addsub (
    .op(op_code), .lhs(dep_a), .rhs(dep_b), .old_c(dep_c[0]),
    .sum(as_sum), .carry(as_carry), .ovf(as_ovf)
  );

  thunk_select #(.W(W)) u_select (
    .op(op_code), .dep_a(dep_a), .dep_b(dep_b), .aux(dep_c[1:0]),
    .as_sum(as_sum), .as_carry(as_carry), .as_ovf(as_ovf), .nzcv(nzcv)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) flags_out <= '0;
    else        flags_out <= {nzcv, {LOW_W{1'b0}}};
  end

  // R10: codes outside the defined set clear the word
  p_bad_op_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !op_legal |=> flags_out == '0);

  // R3: copy mode passes the top nibble of the first word
  p_copy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    op_code == TH_COPY |=> flags_out[BIT_N -: FLAG_N] == $past(dep_a[W-1 -: FLAG_N]));

  // R5: subtract carry means no borrow
  p_sub_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    op_code == TH_SUB |=> flags_out[BIT_C] == $past(dep_a >= dep_b));

  // R7: logical mode takes C and V from the packed bits
  p_logic_cv_r7: assert property (@(posedge clk) disable iff (!rst_n)
    op_code == TH_LOGIC |=> flags_out[BIT_C] == $past(dep_b[0]) && flags_out[BIT_V] == $past(dep_c[0]));

  // R8: single multiply preserves old C and V
  p_mul_cv_r8: assert property (@(posedge clk) disable iff (!rst_n)
    op_code == TH_MUL |=> flags_out[BIT_C] == $past(dep_c[1]) && flags_out[BIT_V] == $past(dep_c[0]));

  // R9: a double product is zero only when both halves are zero
  p_mull_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    op_code == TH_MULL |=> flags_out[BIT_Z] == $past(dep_a == '0 && dep_b == '0));

  // R4: an add can overflow only with equal operand signs
  p_add_ovf_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == TH_ADD && dep_a[W-1] != dep_b[W-1]) |=> !flags_out[BIT_V]);

  // R2: bits below the flags stay clear
  p_low_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> flags_out[LOW_W-1:0] == '0);
endmodule

// File: tb/test_nzcv_thunk_eval.sv
module test_nzcv_thunk_eval;
  localparam int DW = 6;
  localparam int M  = 1 << DW;
  localparam int H  = M / 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [3:0]    op_code = '0;
  logic [DW-1:0] dep_a = '0, dep_b = '0, dep_c = '0;
  logic [DW-1:0] flags_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  nzcv_thunk_eval #(.W(DW)) i_nzcv_thunk_eval (
    .clk(clk), .rst_n(rst_n), .op_code(op_code),
    .dep_a(dep_a), .dep_b(dep_b), .dep_c(dep_c), .flags_out(flags_out)
  );

  function automatic int sgn(input int x);
    return (x >= H) ? x - M : x;
  endfunction

  function automatic logic [DW-1:0] pack(input int n, input int z, input int c, input int v);
    int w;
    w = (n << (DW-1)) | (z << (DW-2)) | (c << (DW-3)) | (v << (DW-4));
    return DW'(w);
  endfunction

  function automatic logic [DW-1:0] model(input int op, input int a, input int b, input int c);
    int r, s, sv, cy;
    case (op)
      0: return DW'(a & ~((1 << (DW-4)) - 1));
      1, 3: begin
        s  = a + b + ((op == 3) ? (c & 1) : 0);
        sv = sgn(a) + sgn(b) + ((op == 3) ? (c & 1) : 0);
        r  = s % M;
        return pack(int'(r >= H), int'(r == 0), int'(s >= M), int'(sv >= H || sv < -H));
      end
      2, 4: begin
        s  = a - b - ((op == 4) ? 1 - (c & 1) : 0);
        sv = sgn(a) - sgn(b) - ((op == 4) ? 1 - (c & 1) : 0);
        cy = int'(s >= 0);
        r  = (s + M) % M;
        return pack(int'(r >= H), int'(r == 0), cy, int'(sv >= H || sv < -H));
      end
      5: return pack(int'(a >= H), int'(a == 0), b & 1, c & 1);
      6: return pack(int'(a >= H), int'(a == 0), (c >> 1) & 1, c & 1);
      7: return pack(int'(b >= H), int'(a == 0 && b == 0), (c >> 1) & 1, c & 1);
      default: return '0;
    endcase
  endfunction

  task automatic check(input string req, input logic [DW-1:0] exp);
    checks++;
    if (flags_out !== exp) begin
      errors++;
      $display("FAIL %s op=%0d a=%0d b=%0d c=%0d actual=%b expected=%b",
               req, op_code, dep_a, dep_b, dep_c, flags_out, exp);
    end
  endtask

  task automatic run(input string req, input int op, input int a, input int b, input int c);
    op_code = 4'(op); dep_a = DW'(a); dep_b = DW'(b); dep_c = DW'(c);
    @(posedge clk);
    @(negedge clk);
    check(req, model(op, a, b, c));
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 190000) begin
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    op_code = 4'd1; dep_a = 6'd5; dep_b = 6'd7;
    repeat (3) @(negedge clk);
    check("R1 reset", '0);
    rst_n = 1'b1;
    op_code = 4'd5; dep_a = 6'd40; dep_b = 6'd1; dep_c = 6'd0;
    #1 check("R1 hold before edge", '0);
    @(posedge clk); @(negedge clk);
    check("R1 latency", pack(1, 0, 1, 0));

    for (int a = 0; a < M; a++) run("R3 R2 copy", 0, a, 0, 0);
    for (int a = 0; a < M; a++)
      for (int b = 0; b < M; b++) begin
        run("R4 add", 1, a, b, 0);
        run("R5 sub", 2, a, b, 0);
        for (int c = 0; c < 2; c++) begin
          run("R6 adc", 3, a, b, c);
          run("R6 sbb", 4, a, b, c);
        end
        for (int c = 0; c < 4; c++) run("R9 mull", 7, a, b, c);
      end
    for (int a = 0; a < M; a++)
      for (int c = 0; c < 4; c++) begin
        run("R7 logic", 5, a, c >> 1, c & 1);
        run("R8 mul", 6, a, 0, c);
      end
    for (int op = 8; op < 16; op++) begin
      run("R10 bad op", op, M - 1, M - 1, 3);
      run("R10 bad op", op, H, 1, 1);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule